// File: doc/BRIEF.md
# Instruction Format Decoder and Operand Address Generator

This block sits at the front of instruction preparation. It takes the first three halfwords of a fetched instruction and decides the instruction format from the top two opcode bits. From that it gives the instruction length in bytes and the operand fields of the second byte. For every storage operand, it drives up to three general-register designators into a register-file read port and adds the returned values to the 12-bit displacement. The result is a 24-bit effective address.

An upstream opcode table supplies a size code for the first storage operand. The block checks the first effective address against that size and raises an alignment error when the address is not a multiple of the size. Every result is registered. A request presented with `in_valid` produces its results, together with a one-cycle `done` pulse, on the next clock. The block has two named states. ST_IDLE holds the last results; it moves to ST_PRESENT when `in_valid` is sampled. ST_PRESENT asserts `done`; it stays in ST_PRESENT while `in_valid` is still high and returns to ST_IDLE when `in_valid` is low.

Top module: `ifd_top`

## Requirements
- R1: `fmt` equals opcode bits hw0[15:14]. Code 0 is register-register, 1 is register-indexed-storage, 2 is register-storage or storage-immediate, and 3 is storage-storage.
- R2: `ilen` is 2 for format 0, 4 for formats 1 and 2, and 6 for format 3.
- R3: `fld_hi` = hw0[7:4], `fld_lo` = hw0[3:0] and `fld_byte` = hw0[7:0], for every format.
- R4: The first address is base + index + displacement modulo 2^24. The base designator is hw1[15:12] and the displacement is hw1[11:0]. Register values contribute only their low 24 bits, and any carry out of bit 23 is lost.
- R5: A base or index designator of 0 adds zero, whatever register 0 holds.
- R6: Only format 1 adds an index, and its designator is hw0[3:0]. Formats 2 and 3 add no index, even when hw0[3:0] is nonzero.
- R7: Format 3 gives a second address, base hw2[15:12] + displacement hw2[11:0] with no index, and sets `ea2_vld`. `ea1_vld` is set for formats 1 to 3. An address that is not produced reads as zero and has its valid flag clear.
- R8: `size_code` 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `align_err` is set only for formats 1 and 2, when the first address is not a multiple of the size. Formats 0 and 3 never set it.
- R9: `done` is high in exactly the cycle after each cycle where `in_valid` is sampled high. Back-to-back requests give back-to-back pulses. The outputs hold their values while no request arrives.
- R10: During reset, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| hw0 | input | 16 | Opcode byte and operand byte |
| hw1 | input | 16 | First base designator and displacement |
| hw2 | input | 16 | Second base designator and displacement |
| size_code | input | 2 | First operand size, log2 of bytes |
| rf_addr_b1 | output | 4 | Register read address, first base |
| rf_addr_x | output | 4 | Register read address, index |
| rf_addr_b2 | output | 4 | Register read address, second base |
| rf_data_b1 | input | 32 | Register value for first base |
| rf_data_x | input | 32 | Register value for index |
| rf_data_b2 | input | 32 | Register value for second base |
| done | output | 1 | Results valid pulse |
| fmt | output | 2 | Format code |
| ilen | output | 3 | Instruction length in bytes |
| fld_hi | output | 4 | Operand byte, high nibble |
| fld_lo | output | 4 | Operand byte, low nibble |
| fld_byte | output | 8 | Operand byte, whole |
| ea1 | output | 24 | First effective address |
| ea1_vld | output | 1 | First address produced |
| ea2 | output | 24 | Second effective address |
| ea2_vld | output | 1 | Second address produced |
| align_err | output | 1 | First operand misaligned |

## Verification
The wrap of the 24-bit sum and the alignment test are judged in the same cycle, on the same registered address. The bench provokes this with base and index values whose sum crosses 2^24. The wrapped remainder is misaligned for an 8-byte operand, so both the truncated address and the error flag must match what the scoreboard computed from the truncated sum. A second overlap comes from requests sent back to back: a new capture happens in the same edge where the previous `done` is seen. The monitor pops one expected item per pulse and checks it against the matching request.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
    typedef enum logic [1:0] {
        FMT_RR  = 2'b00,
        FMT_RX  = 2'b01,
        FMT_RSI = 2'b10,
        FMT_SS  = 2'b11
    } fmt_e;

    typedef enum logic {
        ST_IDLE,
        ST_PRESENT
    } st_e;
endpackage

// File: rtl/ifd_field_split.sv
module ifd_field_split
    import ifd_pkg::*;
#(
    parameter int HW   = 16,
    parameter int RA_W = 4,
    localparam int DW  = HW - RA_W
) (
    input  logic [HW-1:0]   hw0,
    input  logic [HW-1:0]   hw1,
    input  logic [HW-1:0]   hw2,
    output fmt_e            fmt,
    output logic [2:0]      ilen,
    output logic [RA_W-1:0] nib_hi,
    output logic [RA_W-1:0] nib_lo,
    output logic [7:0]      op_byte,
    output logic [RA_W-1:0] base_des [2],
    output logic [DW-1:0]   disp     [2],
    output logic [RA_W-1:0] idx_des,
    output logic            use_ea1,
    output logic            use_ea2
);
    assign fmt     = fmt_e'(hw0[HW-1 -: 2]);
    assign op_byte = hw0[7:0];
    assign nib_hi  = hw0[7:4];
    assign nib_lo  = hw0[3:0];

    assign base_des[0] = hw1[HW-1 -: RA_W];
    assign disp[0]     = hw1[DW-1:0];
    assign base_des[1] = hw2[HW-1 -: RA_W];
    assign disp[1]     = hw2[DW-1:0];

    always_comb begin
        ilen    = 3'd4;
        idx_des = '0;
        use_ea1 = 1'b1;
        use_ea2 = 1'b0;
        unique case (fmt)
            FMT_RR: begin
                ilen    = 3'd2;
                use_ea1 = 1'b0;
            end
            FMT_RX: begin
                idx_des = hw0[3:0];
            end
            FMT_RSI: begin
                ilen = 3'd4;
            end
            FMT_SS: begin
                ilen    = 3'd6;
                use_ea2 = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ifd_agen.sv
module ifd_agen #(
    parameter int AW   = 24,
    parameter int RW   = 32,
    parameter int DW   = 12,
    parameter int RA_W = 4
) (
    input  logic [RA_W-1:0] base_des,
    input  logic [RW-1:0]   base_val,
    input  logic [RA_W-1:0] idx_des,
    input  logic [RW-1:0]   idx_val,
    input  logic [DW-1:0]   disp,
    output logic [AW-1:0]   ea
);
    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] disp_term;

    assign base_term = (base_des == '0) ? '0 : base_val[AW-1:0];
    assign idx_term  = (idx_des  == '0) ? '0 : idx_val[AW-1:0];
    assign disp_term = {{(AW-DW){1'b0}}, disp};
    assign ea        = base_term + idx_term + disp_term;
endmodule

// File: rtl/ifd_align.sv
module ifd_align (
    input  logic [2:0] ea_low,
    input  logic [1:0] size_code,
    input  logic       check_en,
    output logic       misaligned
);
    logic [2:0] mask;

    always_comb begin
        unique case (size_code)
            2'd0: mask = 3'b000;
            2'd1: mask = 3'b001;
            2'd2: mask = 3'b011;
            2'd3: mask = 3'b111;
        endcase
    end

    assign misaligned = check_en && ((ea_low & mask) != 3'b000);
endmodule

// File: rtl/ifd_top.sv
module ifd_top
    import ifd_pkg::*;
#(
    parameter int AW   = 24,
    parameter int RW   = 32,
    parameter int NREG = 16,
    localparam int RA_W = $clog2(NREG),
    localparam int HW   = 16,
    localparam int DW   = HW - RA_W,
    localparam int NEA  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [HW-1:0]   hw0,
    input  logic [HW-1:0]   hw1,
    input  logic [HW-1:0]   hw2,
    input  logic [1:0]      size_code,
    output logic [RA_W-1:0] rf_addr_b1,
    output logic [RA_W-1:0] rf_addr_x,
    output logic [RA_W-1:0] rf_addr_b2,
    input  logic [RW-1:0]   rf_data_b1,
    input  logic [RW-1:0]   rf_data_x,
    input  logic [RW-1:0]   rf_data_b2,
    output logic            done,
    output logic [1:0]      fmt,
    output logic [2:0]      ilen,
    output logic [3:0]      fld_hi,
    output logic [3:0]      fld_lo,
    output logic [7:0]      fld_byte,
    output logic [AW-1:0]   ea1,
    output logic            ea1_vld,
    output logic [AW-1:0]   ea2,
    output logic            ea2_vld,
    output logic            align_err
);
    fmt_e            d_fmt;
    logic [2:0]      d_ilen;
    logic [RA_W-1:0] d_hi, d_lo;
    logic [7:0]      d_byte;
    logic [RA_W-1:0] d_base [NEA];
    logic [DW-1:0]   d_disp [NEA];
    logic [RA_W-1:0] d_idx;
    logic            d_use1, d_use2;
    logic [AW-1:0]   sum    [NEA];
    logic            d_mis;

    ifd_field_split #(.HW(HW), .RA_W(RA_W)) u_split (
        .hw0(hw0), .hw1(hw1), .hw2(hw2),
        .fmt(d_fmt), .ilen(d_ilen),
        .nib_hi(d_hi), .nib_lo(d_lo), .op_byte(d_byte),
        .base_des(d_base), .disp(d_disp), .idx_des(d_idx),
        .use_ea1(d_use1), .use_ea2(d_use2)
    );

    assign rf_addr_b1 = d_base[0];
    assign rf_addr_b2 = d_base[1];
    assign rf_addr_x  = d_idx;

    logic [RW-1:0]   bval [NEA];
    logic [RW-1:0]   xval [NEA];
    logic [RA_W-1:0] xdes [NEA];

    assign bval[0] = rf_data_b1;
    assign bval[1] = rf_data_b2;
    assign xval[0] = rf_data_x;
    assign xval[1] = '0;
    assign xdes[0] = d_idx;
    assign xdes[1] = '0;

    for (genvar g = 0; g < NEA; g++) begin : g_agen
        ifd_agen #(.AW(AW), .RW(RW), .DW(DW), .RA_W(RA_W)) u_agen (
            .base_des(d_base[g]), .base_val(bval[g]),
            .idx_des(xdes[g]),    .idx_val(xval[g]),
            .disp(d_disp[g]),     .ea(sum[g])
        );
    end

    ifd_align u_align (
        .ea_low(sum[0][2:0]),
        .size_code(size_code),
        .check_en(d_fmt == FMT_RX || d_fmt == FMT_RSI),
        .misaligned(d_mis)
    );

    st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (in_valid)  state_nx = ST_PRESENT;
            ST_PRESENT: if (!in_valid) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign done = (state == ST_PRESENT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt       <= '0;
            ilen      <= '0;
            fld_hi    <= '0;
            fld_lo    <= '0;
            fld_byte  <= '0;
            ea1       <= '0;
            ea1_vld   <= 1'b0;
            ea2       <= '0;
            ea2_vld   <= 1'b0;
            align_err <= 1'b0;
        end else if (in_valid) begin
            fmt       <= d_fmt;
            ilen      <= d_ilen;
            fld_hi    <= d_hi;
            fld_lo    <= d_lo;
            fld_byte  <= d_byte;
            ea1       <= d_use1 ? sum[0] : '0;
            ea1_vld   <= d_use1;
            ea2       <= d_use2 ? sum[1] : '0;
            ea2_vld   <= d_use2;
            align_err <= d_mis;
        end
    end
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          done,
    input logic [1:0]    fmt,
    input logic [2:0]    ilen,
    input logic [AW-1:0] ea1,
    input logic          ea1_vld,
    input logic [AW-1:0] ea2,
    input logic          ea2_vld,
    input logic          align_err
);
    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea1) && $stable(ea2) && $stable(fmt)));

    assert_len_by_format_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ilen == ((fmt == 2'b00) ? 3'd2 : (fmt == 2'b11) ? 3'd6 : 3'd4)));

    assert_second_addr_ss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ea2_vld == (fmt == 2'b11)) && (ea1_vld == (fmt != 2'b00)));

    assert_unused_addr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ea2_vld) |-> (ea2 == '0));

    assert_no_align_rr_ss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (fmt == 2'b00 || fmt == 2'b11)) |-> !align_err);
endmodule

bind ifd_top ifd_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .done(done),
    .fmt(fmt), .ilen(ilen), .ea1(ea1), .ea1_vld(ea1_vld),
    .ea2(ea2), .ea2_vld(ea2_vld), .align_err(align_err)
);

// File: tb/sim_ifd_top.sv
module sim_ifd_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] hw0 = '0, hw1 = '0, hw2 = '0;
    logic [1:0]  size_code = '0;
    logic [3:0]  rf_addr_b1, rf_addr_x, rf_addr_b2;
    logic [31:0] rf_data_b1, rf_data_x, rf_data_b2;
    logic        done, ea1_vld, ea2_vld, align_err;
    logic [1:0]  fmt;
    logic [2:0]  ilen;
    logic [3:0]  fld_hi, fld_lo;
    logic [7:0]  fld_byte;
    logic [23:0] ea1, ea2;

    logic [31:0] regs [16];

    assign rf_data_b1 = regs[rf_addr_b1];
    assign rf_data_x  = regs[rf_addr_x];
    assign rf_data_b2 = regs[rf_addr_b2];

    always #(CLK_PERIOD/2) clk = ~clk;

    ifd_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hw0(hw0), .hw1(hw1), .hw2(hw2), .size_code(size_code),
        .rf_addr_b1(rf_addr_b1), .rf_addr_x(rf_addr_x), .rf_addr_b2(rf_addr_b2),
        .rf_data_b1(rf_data_b1), .rf_data_x(rf_data_x), .rf_data_b2(rf_data_b2),
        .done(done), .fmt(fmt), .ilen(ilen),
        .fld_hi(fld_hi), .fld_lo(fld_lo), .fld_byte(fld_byte),
        .ea1(ea1), .ea1_vld(ea1_vld), .ea2(ea2), .ea2_vld(ea2_vld),
        .align_err(align_err)
    );

    typedef struct {
        logic [1:0]  fmt;
        logic [2:0]  ilen;
        logic [7:0]  fbyte;
        logic [23:0] ea1;
        logic        v1;
        logic [23:0] ea2;
        logic        v2;
        logic        err;
        string       ea_tag;
    } exp_t;

    exp_t sb[$];
    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] term(input logic [3:0] des);
        return (des == 4'd0) ? 24'd0 : regs[des][23:0];
    endfunction

    function automatic exp_t model(input logic [15:0] a, input logic [15:0] b,
                                   input logic [15:0] c, input logic [1:0] sz,
                                   input string tag);
        exp_t e;
        logic [23:0] x;
        e.fmt   = a[15:14];
        e.ilen  = (e.fmt == 2'd0) ? 3'd2 : (e.fmt == 2'd3) ? 3'd6 : 3'd4;
        e.fbyte = a[7:0];
        x       = (e.fmt == 2'd1) ? term(a[3:0]) : 24'd0;
        e.v1    = (e.fmt != 2'd0);
        e.ea1   = e.v1 ? (term(b[15:12]) + x + {12'd0, b[11:0]}) : 24'd0;
        e.v2    = (e.fmt == 2'd3);
        e.ea2   = e.v2 ? (term(c[15:12]) + {12'd0, c[11:0]}) : 24'd0;
        e.err   = (e.fmt == 2'd1 || e.fmt == 2'd2) && ((e.ea1 % (24'd1 << sz)) != 0);
        e.ea_tag = tag;
        return e;
    endfunction

    task automatic send(input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] c, input logic [1:0] sz, input string tag);
        hw0 = a; hw1 = b; hw2 = c; size_code = sz; in_valid = 1'b1;
        sb.push_back(model(a, b, c, sz, tag));
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "done with no request", 32'(done), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(fmt == e.fmt, "R1", "fmt", 32'(fmt), 32'(e.fmt));
                chk(ilen == e.ilen, "R2", "ilen", 32'(ilen), 32'(e.ilen));
                chk({fld_hi, fld_lo} == e.fbyte && fld_byte == e.fbyte, "R3", "fields",
                    {16'd0, fld_hi, fld_lo, fld_byte}, {16'd0, e.fbyte, e.fbyte});
                chk(ea1 == e.ea1, e.ea_tag, "ea1", 32'(ea1), 32'(e.ea1));
                chk(ea2 == e.ea2 && ea2_vld == e.v2 && ea1_vld == e.v1, "R7", "ea2/valids",
                    {6'd0, ea1_vld, ea2_vld, ea2}, {6'd0, e.v1, e.v2, e.ea2});
                chk(align_err == e.err, "R8", "align_err", 32'(align_err), 32'(e.err));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] held;
        for (int i = 0; i < 16; i++) regs[i] = 32'hA500_0000 | (i * 32'h0001_1110);
        regs[0]  = 32'h00FF_FFF0;
        regs[9]  = 32'h77FF_FFF8;
        regs[10] = 32'h0000_0010;

        repeat (3) @(negedge clk);
        // R10: outputs cleared during reset
        chk(done == 1'b0, "R10", "done in reset", 32'(done), 32'd0);
        chk(ea1 == 24'd0 && ea2 == 24'd0 && fmt == 2'd0 && ilen == 3'd0 && !align_err,
            "R10", "results in reset", {ea1, 5'd0, ilen}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // register-register form, never an address (R1 R2 R3 R7 R8)
        send(16'h1A37, 16'h5123, 16'h6456, 2'd3, "R7");
        idle(2);
        // indexed form with base and index (R4 R6)
        send(16'h5E57, 16'h5123, 16'h0000, 2'd2, "R4");
        // back to back: zero designators ignore register 0 (R5 R9)
        send(16'h4A60, 16'h0ABC, 16'h0000, 2'd0, "R5");
        // wrap past 2^24, leaves 8-byte operand misaligned (R4 R8)
        send(16'h478A, 16'h9004, 16'h0000, 2'd3, "R4");
        // wrap that lands aligned
        send(16'h478A, 16'h9000, 16'h0000, 2'd3, "R4");
        idle(1);
        // storage form: index nibble nonzero but ignored, odd halfword (R6 R8)
        send(16'h902F, 16'h3001, 16'h0000, 2'd1, "R6");
        // immediate form, byte operand never misaligned (R8)
        send(16'h92C4, 16'h3001, 16'h0000, 2'd0, "R8");
        // storage-storage: two addresses, index nibble ignored, no alignment check (R6 R7 R8)
        send(16'hD245, 16'h4FFF, 16'h0800, 2'd3, "R6");
        send(16'hFF0F, 16'hF7FF, 16'hE001, 2'd3, "R7");
        idle(2);

        // R9: hold results while no request, even when inputs move
        held = ea1;
        hw0 = 16'h5555; hw1 = 16'h1234; hw2 = 16'h4321;
        idle(3);
        chk(ea1 == held, "R9", "ea1 held", 32'(ea1), 32'(held));
        chk(done == 1'b0, "R9", "done low when idle", 32'(done), 32'd0);
        chk(sb.size() == 0, "R9", "pending results", 32'(sb.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule